// File: doc/BRIEF.md
# Write-Guarded Interrupt Register Front End

This block is a small 32-bit register slave that collects single-cycle event pulses into a sticky interrupt status word. It compares that word against a mask and drives one level interrupt line. Software reads the status and clears bits by writing ones to them. The mask cannot be written directly. Software clears mask bits through an enable strobe address and sets them through a disable strobe address.

Every register except the guard register is protected by a passcode. After reset the guard is closed, and writes to any other register are dropped. Software opens the guard by writing one exact key value. Writing any other value closes it again. The block also holds a one-bit program-lock flag. Once that flag is set, only reset clears it.

The bus is word-only and has no handshake. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is a combinational decode of `bus_addr`.

Top module: `girq_front`

Register word map, with byte addresses:

| Byte address | Register | Access |
|---|---|---|
| 0x00 | guard | read/write |
| 0x04 | status | read, write-one-to-clear |
| 0x08 | mask | read-only |
| 0x0C | enable strobe | write, reads 0 |
| 0x10 | disable strobe | write, reads 0 |
| 0x14 | program-lock | read/write, bit 0 only |

## Requirements
- R1: The guard register (0x00) reads 1 after reset. A write of exactly 0x0000DF0D makes it read 0. A write of any other value makes it read 1.
- R2: While the guard reads 1, writes to any address other than 0x00 change nothing. The guard register itself stays writable at all times.
- R3: Status (0x04) bit 31 and bits 0 to 14 are implemented. Writing 1 to an implemented bit clears it. Bits 15 to 30 always read 0.
- R4: The mask (0x08) resets to 0x80007FFF. Writes to 0x08 have no effect.
- R5: A write to 0x0C clears the mask bits where the write data is 1. A write to 0x10 sets the mask bits where the write data is 1. Both addresses read 0.
- R6: `irq_o` is high exactly when some bit of status is 1 and the same bit of the mask is 0.
- R7: The program-lock register (0x14) stores only bit 0 of the write data and reads with bits 31:1 at 0. Once it holds 1, it keeps 1 until reset.
- R8: An event pulse on `event_in[i]` sets status bit i, for i from 0 to 14. In this mapping bit 0 is program done, bit 1 program error, bit 2 read done and bit 3 read error. A pulse on `event_in[15]` (bus slave error) sets status bit 31. Each status bit is set on the clock edge where its input is high.
- R9: When an event pulse and a write-one-to-clear reach the same status bit on the same edge, the bit ends up set.
- R10: Unmapped addresses read 0 and ignore writes. This includes word addresses above 0x14 and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| event_in | input | LOW_SRC+1 (16) | Event pulses; the top bit maps to status bit 31 |
| irq_o | output | 1 | Interrupt level |

## Verification
Two functions can act on one status bit in the same cycle: a hardware event setting the bit and a software write-one-to-clear removing it. The bench drives an event pulse on read error (bit 3) in the same cycle as a clear write carrying bit 3. It then reads the status back and expects the bit to be set. A second collision pairs the guard with a strobe: a write to the disable strobe lands while the guard is closed. The bench checks that the mask and `irq_o` do not change.

// File: rtl/girq_pkg.sv
package girq_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      SLOT_GUARD = 3'd0,
      SLOT_STAT  = 3'd1,
      SLOT_MASK  = 3'd2,
      SLOT_EN    = 3'd3,
      SLOT_DIS   = 3'd4,
      SLOT_PLOCK = 3'd5,
      SLOT_NONE  = 3'd7
   } slot_e;

   // Builds the set of implemented status/mask bits: low sources plus bit 31.
   function automatic logic [WORD_W-1:0] impl_bits(input int low_src);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < low_src; i++) m[i] = 1'b1;
      m[WORD_W-1] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/girq_guard.sv
module girq_guard #(
   parameter int                W   = 32,
   parameter logic [W-1:0]      KEY = 32'h0000_DF0D
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic         closed_o
);
   logic closed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  closed_q <= 1'b1;
      else if (we) closed_q <= (wdata != KEY);
   end

   assign closed_o = closed_q;

   // R1
   key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == KEY) |=> !closed_o);
   // R1
   other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata != KEY) |=> closed_o);
endmodule

// File: rtl/girq_sticky.sv
module girq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic din,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (we) q <= q | din;
   end

   assign q_o = q;

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_o |=> q_o);
endmodule

// File: rtl/girq_core.sv
module girq_core
   import girq_pkg::*;
#(
   parameter int LOW_SRC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOW_SRC:0]  ev_i,
   input  logic              clr_we,
   input  logic              en_we,
   input  logic              dis_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] stat_o,
   output logic [WORD_W-1:0] mask_o,
   output logic              irq_o
);
   localparam logic [WORD_W-1:0] IMPL = impl_bits(LOW_SRC);

   logic [WORD_W-1:0] ev_word, stat_q, mask_q, clr_bits;

   // Route event inputs onto status positions; the top input lands on bit 31.
   for (genvar g = 0; g < WORD_W; g++) begin : g_map
      if (g < LOW_SRC) begin : g_low
         assign ev_word[g] = ev_i[g];
      end else if (g == WORD_W-1) begin : g_top
         assign ev_word[g] = ev_i[LOW_SRC];
      end else begin : g_rsvd
         assign ev_word[g] = 1'b0;
      end
   end

   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= IMPL;
      end else begin
         stat_q <= ((stat_q & ~clr_bits) | ev_word) & IMPL;
         if (en_we)       mask_q <= mask_q & ~wdata;
         else if (dis_we) mask_q <= (mask_q | wdata) & IMPL;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign irq_o  = |(stat_q & ~mask_q);

   // R8 R9
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i != '0) |=> ((stat_o & $past(ev_word)) == $past(ev_word)));
   // R5
   enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> ((mask_o & $past(wdata)) == '0));
   // R5
   disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_we |=> ((mask_o & $past(wdata) & IMPL) == ($past(wdata) & IMPL)));
   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o | mask_o) & ~IMPL) == '0);
endmodule

// File: rtl/girq_front.sv
module girq_front
   import girq_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          LOW_SRC = 15,
   parameter logic [31:0] KEY     = 32'h0000_DF0D
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [LOW_SRC:0]    event_in,
   output logic                irq_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("girq_front: ADDR_W must be at least 5");
   end
   if (LOW_SRC < 1 || LOW_SRC > WORD_W-2) begin : g_bad_src
      $error("girq_front: LOW_SRC must lie in 1..30");
   end

   slot_e             slot;
   logic              closed, plock;
   logic              wr_guard, wr_ok;
   logic [WORD_W-1:0] stat, mask;
   logic [IDX_W-1:0]  widx;

   assign widx = bus_addr[ADDR_W-1:2];

   always_comb begin
      slot = SLOT_NONE;
      if (bus_addr[1:0] == 2'b00) begin
         case (widx)
            IDX_W'(0): slot = SLOT_GUARD;
            IDX_W'(1): slot = SLOT_STAT;
            IDX_W'(2): slot = SLOT_MASK;
            IDX_W'(3): slot = SLOT_EN;
            IDX_W'(4): slot = SLOT_DIS;
            IDX_W'(5): slot = SLOT_PLOCK;
            default:   slot = SLOT_NONE;
         endcase
      end
   end

   assign wr_guard = bus_wr && slot == SLOT_GUARD;
   assign wr_ok    = bus_wr && !closed;

   girq_guard #(.W(WORD_W), .KEY(KEY)) u_guard (
      .clk(clk), .rst_n(rst_n), .we(wr_guard), .wdata(bus_wdata), .closed_o(closed));

   girq_core #(.LOW_SRC(LOW_SRC)) u_core (
      .clk(clk), .rst_n(rst_n), .ev_i(event_in),
      .clr_we(wr_ok && slot == SLOT_STAT),
      .en_we (wr_ok && slot == SLOT_EN),
      .dis_we(wr_ok && slot == SLOT_DIS),
      .wdata(bus_wdata), .stat_o(stat), .mask_o(mask), .irq_o(irq_o));

   girq_sticky u_plock (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && slot == SLOT_PLOCK),
      .din(bus_wdata[0]), .q_o(plock));

   always_comb begin
      unique case (slot)
         SLOT_GUARD: bus_rdata = {{(WORD_W-1){1'b0}}, closed};
         SLOT_STAT:  bus_rdata = stat;
         SLOT_MASK:  bus_rdata = mask;
         SLOT_PLOCK: bus_rdata = {{(WORD_W-1){1'b0}}, plock};
         default:    bus_rdata = '0;
      endcase
   end

   // R2
   closed_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && bus_wr && slot != SLOT_GUARD) |=> $stable(mask));
   // R2
   closed_plock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && bus_wr && slot == SLOT_PLOCK) |=> $stable(plock));
endmodule

// File: tb/girq_front_tb.sv
module girq_front_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] event_in = '0;
   logic        irq_o;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   girq_front u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_in(event_in), .irq_o(irq_o));

   // Vector: write address, write data, read address, expected read value.
   typedef struct packed {
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] expv;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{8'h0C, 32'h0000_0005, 8'h08, 32'h8000_7FFA},  // R5 enable clears
      '{8'h0C, 32'h0000_0000, 8'h0C, 32'h0000_0000},  // R5 reads 0
      '{8'h10, 32'h0000_0001, 8'h08, 32'h8000_7FFB},  // R5 disable sets
      '{8'h10, 32'h0000_0000, 8'h10, 32'h0000_0000},  // R5 reads 0
      '{8'h08, 32'h0000_0000, 8'h08, 32'h8000_7FFB},  // R4 mask not writable
      '{8'h14, 32'h0000_0006, 8'h14, 32'h0000_0000},  // R7 bit 0 only
      '{8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0001},  // R7 set
      '{8'h14, 32'h0000_0000, 8'h14, 32'h0000_0001},  // R7 sticky
      '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},  // R10 unmapped
      '{8'h11, 32'hFFFF_FFFF, 8'h08, 32'h8000_7FFB}   // R10 misaligned write
   };

   task automatic cyc_drive(input logic wr, input logic [7:0] a, input logic [31:0] d,
                            input logic [15:0] ev);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; event_in = ev;
      @(negedge clk);
      bus_wr = 1'b0; event_in = '0;
   endtask

   task automatic check_rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
      bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== expv) begin
         fails++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, expv);
      end
   endtask

   task automatic check_irq(input logic expv, input string tag);
      checks++;
      if (irq_o !== expv) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_rd(8'h00, 32'h1, "R1 guard reset");
      check_rd(8'h08, 32'h8000_7FFF, "R4 mask reset");
      check_rd(8'h04, 32'h0, "R3 status reset");
      check_irq(1'b0, "R6 reset");

      // R2: guard closed, writes dropped
      cyc_drive(1'b1, 8'h0C, 32'hFFFF_FFFF, '0);
      check_rd(8'h08, 32'h8000_7FFF, "R2 enable dropped");
      cyc_drive(1'b1, 8'h14, 32'h1, '0);
      check_rd(8'h14, 32'h0, "R2 plock dropped");

      // R1: wrong key keeps closed, right key opens
      cyc_drive(1'b1, 8'h00, 32'h0000_1234, '0);
      check_rd(8'h00, 32'h1, "R1 wrong key");
      cyc_drive(1'b1, 8'h00, 32'h0000_DF0D, '0);
      check_rd(8'h00, 32'h0, "R1 key opens");

      for (int i = 0; i < NV; i++) begin
         cyc_drive(1'b1, VT[i].waddr, VT[i].wdata, '0);
         check_rd(VT[i].raddr, VT[i].expv, $sformatf("table row %0d (R4 R5 R7 R10)", i));
      end

      // R8/R6: mask is 0x80007FFB, bit 2 unmasked
      cyc_drive(1'b0, 8'h00, 32'h0, 16'h0001);
      check_rd(8'h04, 32'h0000_0001, "R8 bit0 event");
      check_irq(1'b0, "R6 masked source");
      cyc_drive(1'b0, 8'h00, 32'h0, 16'h0004);
      check_rd(8'h04, 32'h0000_0005, "R8 bit2 event");
      check_irq(1'b1, "R6 unmasked source");
      cyc_drive(1'b1, 8'h04, 32'h0000_0004, '0);
      check_rd(8'h04, 32'h0000_0001, "R3 w1c bit2");
      check_irq(1'b0, "R6 after clear");
      cyc_drive(1'b0, 8'h00, 32'h0, 16'h8000);
      check_rd(8'h04, 32'h8000_0001, "R8 top source to bit31");
      cyc_drive(1'b1, 8'h04, 32'hFFFF_FFFF, '0);
      check_rd(8'h04, 32'h0, "R3 clear all");

      // R9: event and clear on bit 3 in one cycle
      cyc_drive(1'b1, 8'h04, 32'h0000_0008, 16'h0008);
      check_rd(8'h04, 32'h0000_0008, "R9 event beats clear");
      cyc_drive(1'b1, 8'h0C, 32'h0000_0008, '0);
      check_irq(1'b1, "R6 enable raises irq");
      cyc_drive(1'b1, 8'h05, 32'h0, '0);
      check_rd(8'h05, 32'h0, "R10 misaligned read");

      // R2: close guard, disable write and clear dropped
      cyc_drive(1'b1, 8'h00, 32'h0, '0);
      check_rd(8'h00, 32'h1, "R1 reclose");
      cyc_drive(1'b1, 8'h10, 32'hFFFF_FFFF, '0);
      check_irq(1'b1, "R2 disable dropped");
      cyc_drive(1'b1, 8'h04, 32'hFFFF_FFFF, '0);
      check_rd(8'h04, 32'h0000_0008, "R2 clear dropped");

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule